// File: doc/BRIEF.md
# Privileged Trap Entry Controller

This block turns a signalled trap into the architectural state changes of trap entry. In the cycle where `trap_valid_i` is high it reads the trap cause (the top bit marks an interrupt), the PC of the trapping instruction and the trap value. It also reads the current privilege, the status word, the two delegation masks, both trap vectors and the debug controls. From these it picks one of five routes: debug ROM entry or debug exception vector while already in debug mode, fresh entry into debug mode on a breakpoint, supervisor entry, or machine entry.

All results are registered. On the next clock edge the block presents the new PC, the new privilege, the updated status word and the cause/EPC/value registers of whichever level took the trap. It also presents the saved debug PC and privilege on a debug entry, and a one-cycle `redirect_o` strobe that tells the fetch unit to follow `pc_o`. The surrounding core feeds `prv_o` and `status_o` back as `cur_prv_i` and `status_i`.

Privilege codes are U=0, S=1, M=3; code 2 is reserved and is handled like M for delegation. The status word uses bit 0 for SIE, bit 1 for MIE, bit 2 for SPIE, bit 3 for MPIE, bit 4 for SPP and bits 6:5 for MPP. The breakpoint exception code is 3.

Top module: `trap_entry_ctl`

## Requirements
- R1: Synchronous reset sets `pc_o` to `RST_PC` and `prv_o` to 3. It clears `redirect_o`, `dbg_enter_o`, `status_o` and all cause, EPC, value and debug-save outputs.
- R2: With `dbg_active_i` high, a trap sets `pc_o` to `DBG_ROM_PC` if it is a breakpoint (non-interrupt, code 3) and to `DBG_EXC_PC` otherwise. `prv_o`, `status_o`, all cause/EPC/value outputs and the debug-save outputs keep their values.
- R3: Outside debug mode, a breakpoint taken in a mode whose own ebreak-to-debug input is high (`ebk_m_i` for 3, `ebk_s_i` for 1, `ebk_u_i` for 0) has these effects. It pulses `dbg_enter_o`, loads `dpc_o` with the trap PC and `dprv_o` with the current privilege, sets `prv_o` to 3 and `pc_o` to `DBG_ROM_PC`. The supervisor and machine registers and `status_o` are left unchanged.
- R4: The delegation index is the cause with the interrupt flag (bit XLEN-1) removed. Interrupts look it up in `int_deleg_i` and exceptions in `exc_deleg_i`. The trap goes to supervisor only if the current privilege is 0 or 1, the index is below XLEN, and the looked-up bit is 1; every other trap goes to machine.
- R5: Supervisor entry sets `pc_o` to `stvec_i`. It loads `scause_o` with the full cause, `sepc_o` with the trap PC and `stval_o` with the trap value. It sets SPIE to the input SIE, SPP to bit 0 of the old privilege, and SIE to 0, with the other status bits taken from `status_i`. It sets `prv_o` to 1, and the machine cause/EPC/value outputs keep their values.
- R6: Machine entry sets `pc_o` to `mtvec_i` with bit 0 cleared. It adds 4 times the delegation index only when `mtvec_i[0]` is 1 and the trap is an interrupt.
- R7: Machine entry loads `mcause_o`, `mepc_o` and `mtval_o`. It sets MPIE to the input MIE, MPP to the old privilege, and MIE to 0, with the other status bits from `status_i`. It sets `prv_o` to 3, and the supervisor cause/EPC/value outputs keep their values.
- R8: In a cycle with `trap_valid_i` low, every output keeps its value on the next edge except `redirect_o` and `dbg_enter_o`, which go low.
- R9: `redirect_o` is high for exactly the one cycle after each cycle in which `trap_valid_i` is high, and the results of that trap are visible in the same cycle.
- R10: A breakpoint whose ebreak-to-debug input is set only for a mode other than the current one takes the normal supervisor or machine path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid_i | input | 1 | A trap is signalled this cycle |
| trap_cause_i | input | XLEN | Cause; top bit set for interrupts |
| trap_epc_i | input | XLEN | PC of the trapping instruction |
| trap_tval_i | input | XLEN | Trap value |
| cur_prv_i | input | 2 | Current privilege |
| status_i | input | 7 | Current status word |
| exc_deleg_i | input | XLEN | Exception delegation mask |
| int_deleg_i | input | XLEN | Interrupt delegation mask |
| stvec_i | input | XLEN | Supervisor trap vector |
| mtvec_i | input | XLEN | Machine trap vector; bit 0 selects vectored interrupts |
| dbg_active_i | input | 1 | Core is in debug mode |
| ebk_m_i | input | 1 | Breakpoint in M enters debug |
| ebk_s_i | input | 1 | Breakpoint in S enters debug |
| ebk_u_i | input | 1 | Breakpoint in U enters debug |
| redirect_o | output | 1 | One-cycle strobe: follow pc_o |
| pc_o | output | XLEN | Next PC |
| prv_o | output | 2 | New privilege |
| status_o | output | 7 | New status word |
| scause_o | output | XLEN | Supervisor cause |
| sepc_o | output | XLEN | Supervisor EPC |
| stval_o | output | XLEN | Supervisor trap value |
| mcause_o | output | XLEN | Machine cause |
| mepc_o | output | XLEN | Machine EPC |
| mtval_o | output | XLEN | Machine trap value |
| dbg_enter_o | output | 1 | One-cycle strobe: debug mode entered |
| dpc_o | output | XLEN | Saved PC on debug entry |
| dprv_o | output | 2 | Saved privilege on debug entry |

## Verification
Every piece of state in this block is an output register, so a wrong route or a corrupted field shows at the ports on the first edge after the trap. A bad route shows as a wrong `pc_o` and `prv_o` together with the wrong level's cause/EPC registers moving. A bad stack update shows as a wrong `status_o`. Because the outputs must also hold across idle cycles, a spurious write is visible one cycle after any idle cycle. Comparing all outputs after every cycle against a procedural model therefore localises a fault to the cycle that caused it.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  localparam int STW      = 7;
  localparam int ST_SIE   = 0;
  localparam int ST_MIE   = 1;
  localparam int ST_SPIE  = 2;
  localparam int ST_MPIE  = 3;
  localparam int ST_SPP   = 4;
  localparam int ST_MPP_L = 5;
  localparam int ST_MPP_H = 6;

  localparam int BKPT_CODE = 3;

  typedef enum logic [2:0] {
    RT_DBG_ROM,
    RT_DBG_EXC,
    RT_DBG_ENTER,
    RT_SUP,
    RT_MACH
  } route_e;
endpackage

// File: rtl/trap_route.sv
module trap_route
  import trap_entry_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int IDXW = XLEN - 1,
  localparam int LGX  = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] cause_i,
  input  logic [1:0]      prv_i,
  input  logic            dbg_active_i,
  input  logic            ebk_m_i,
  input  logic            ebk_s_i,
  input  logic            ebk_u_i,
  input  logic [XLEN-1:0] exc_deleg_i,
  input  logic [XLEN-1:0] int_deleg_i,
  output route_e          route_o,
  output logic            irq_o,
  output logic [IDXW-1:0] idx_o
);
  logic            is_bkpt;
  logic            ebk_here;
  logic            in_range;
  logic [XLEN-1:0] mask;

  assign irq_o    = cause_i[XLEN-1];
  assign idx_o    = cause_i[IDXW-1:0];
  assign is_bkpt  = !irq_o && (idx_o == IDXW'(BKPT_CODE));
  assign in_range = idx_o < IDXW'(XLEN);
  assign mask     = irq_o ? int_deleg_i : exc_deleg_i;

  always_comb begin
    case (prv_i)
      PRV_M:   ebk_here = ebk_m_i;
      PRV_S:   ebk_here = ebk_s_i;
      PRV_U:   ebk_here = ebk_u_i;
      default: ebk_here = 1'b0;
    endcase
  end

  always_comb begin
    if (dbg_active_i)
      route_o = is_bkpt ? RT_DBG_ROM : RT_DBG_EXC;
    else if (is_bkpt && ebk_here)
      route_o = RT_DBG_ENTER;
    else if ((prv_i == PRV_U || prv_i == PRV_S) && in_range && mask[idx_o[LGX-1:0]])
      route_o = RT_SUP;
    else
      route_o = RT_MACH;
  end
endmodule

// File: rtl/trap_vec_calc.sv
module trap_vec_calc
  import trap_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] DBG_ROM_PC = 'h800,
  parameter logic [XLEN-1:0] DBG_EXC_PC = 'h808,
  localparam int IDXW = XLEN - 1
) (
  input  route_e          route_i,
  input  logic            irq_i,
  input  logic [IDXW-1:0] idx_i,
  input  logic [XLEN-1:0] stvec_i,
  input  logic [XLEN-1:0] mtvec_i,
  output logic [XLEN-1:0] pc_o
);
  logic [XLEN-1:0] mbase;
  logic [XLEN-1:0] moffs;

  assign mbase = {mtvec_i[XLEN-1:1], 1'b0};
  assign moffs = (mtvec_i[0] && irq_i) ? XLEN'({idx_i, 2'b00}) : '0;

  always_comb begin
    case (route_i)
      RT_DBG_ROM, RT_DBG_ENTER: pc_o = DBG_ROM_PC;
      RT_DBG_EXC:               pc_o = DBG_EXC_PC;
      RT_SUP:                   pc_o = stvec_i;
      default:                  pc_o = mbase + moffs;
    endcase
  end
endmodule

// File: rtl/trap_entry_ctl.sv
module trap_entry_ctl
  import trap_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] RST_PC     = 'h1000,
  parameter logic [XLEN-1:0] DBG_ROM_PC = 'h800,
  parameter logic [XLEN-1:0] DBG_EXC_PC = 'h808
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trap_valid_i,
  input  logic [XLEN-1:0] trap_cause_i,
  input  logic [XLEN-1:0] trap_epc_i,
  input  logic [XLEN-1:0] trap_tval_i,
  input  logic [1:0]      cur_prv_i,
  input  logic [6:0]      status_i,
  input  logic [XLEN-1:0] exc_deleg_i,
  input  logic [XLEN-1:0] int_deleg_i,
  input  logic [XLEN-1:0] stvec_i,
  input  logic [XLEN-1:0] mtvec_i,
  input  logic            dbg_active_i,
  input  logic            ebk_m_i,
  input  logic            ebk_s_i,
  input  logic            ebk_u_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] pc_o,
  output logic [1:0]      prv_o,
  output logic [6:0]      status_o,
  output logic [XLEN-1:0] scause_o,
  output logic [XLEN-1:0] sepc_o,
  output logic [XLEN-1:0] stval_o,
  output logic [XLEN-1:0] mcause_o,
  output logic [XLEN-1:0] mepc_o,
  output logic [XLEN-1:0] mtval_o,
  output logic            dbg_enter_o,
  output logic [XLEN-1:0] dpc_o,
  output logic [1:0]      dprv_o
);
  localparam int IDXW = XLEN - 1;

  route_e          route;
  logic            irq;
  logic [IDXW-1:0] idx;
  logic [XLEN-1:0] next_pc;
  logic [STW-1:0]  st_sup;
  logic [STW-1:0]  st_mach;

  trap_route #(.XLEN(XLEN)) route_i (
    .cause_i      (trap_cause_i),
    .prv_i        (cur_prv_i),
    .dbg_active_i (dbg_active_i),
    .ebk_m_i      (ebk_m_i),
    .ebk_s_i      (ebk_s_i),
    .ebk_u_i      (ebk_u_i),
    .exc_deleg_i  (exc_deleg_i),
    .int_deleg_i  (int_deleg_i),
    .route_o      (route),
    .irq_o        (irq),
    .idx_o        (idx)
  );

  trap_vec_calc #(
    .XLEN       (XLEN),
    .DBG_ROM_PC (DBG_ROM_PC),
    .DBG_EXC_PC (DBG_EXC_PC)
  ) vec_i (
    .route_i (route),
    .irq_i   (irq),
    .idx_i   (idx),
    .stvec_i (stvec_i),
    .mtvec_i (mtvec_i),
    .pc_o    (next_pc)
  );

  // stacked status words for the two ordinary entry routes
  always_comb begin
    st_sup          = status_i;
    st_sup[ST_SPIE] = status_i[ST_SIE];
    st_sup[ST_SPP]  = cur_prv_i[0];
    st_sup[ST_SIE]  = 1'b0;
    st_mach                    = status_i;
    st_mach[ST_MPIE]           = status_i[ST_MIE];
    st_mach[ST_MPP_H:ST_MPP_L] = cur_prv_i;
    st_mach[ST_MIE]            = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_o  <= 1'b0;
      dbg_enter_o <= 1'b0;
      pc_o        <= RST_PC;
      prv_o       <= PRV_M;
      status_o    <= '0;
      scause_o    <= '0;
      sepc_o      <= '0;
      stval_o     <= '0;
      mcause_o    <= '0;
      mepc_o      <= '0;
      mtval_o     <= '0;
      dpc_o       <= '0;
      dprv_o      <= '0;
    end else begin
      redirect_o  <= trap_valid_i;
      dbg_enter_o <= 1'b0;
      if (trap_valid_i) begin
        pc_o <= next_pc;
        case (route)
          RT_DBG_ENTER: begin
            dbg_enter_o <= 1'b1;
            dpc_o       <= trap_epc_i;
            dprv_o      <= cur_prv_i;
            prv_o       <= PRV_M;
          end
          RT_SUP: begin
            scause_o <= trap_cause_i;
            sepc_o   <= trap_epc_i;
            stval_o  <= trap_tval_i;
            status_o <= st_sup;
            prv_o    <= PRV_S;
          end
          RT_MACH: begin
            mcause_o <= trap_cause_i;
            mepc_o   <= trap_epc_i;
            mtval_o  <= trap_tval_i;
            status_o <= st_mach;
            prv_o    <= PRV_M;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk
  import trap_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] DBG_ROM_PC = 'h800
) (
  input logic            clk,
  input logic            rst,
  input logic            trap_valid_i,
  input logic            dbg_active_i,
  input logic            redirect_o,
  input logic [XLEN-1:0] pc_o,
  input logic [1:0]      prv_o,
  input logic [6:0]      status_o,
  input logic [XLEN-1:0] scause_o,
  input logic [XLEN-1:0] sepc_o,
  input logic [XLEN-1:0] mcause_o,
  input logic [XLEN-1:0] mepc_o,
  input logic            dbg_enter_o
);
  // R2
  dbg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    trap_valid_i && dbg_active_i |=> redirect_o && !dbg_enter_o && $stable(prv_o)
      && $stable(status_o) && $stable(mcause_o) && $stable(scause_o));

  // R3
  dbg_enter_chk: assert property (@(posedge clk) disable iff (rst)
    dbg_enter_o |-> redirect_o && prv_o == PRV_M && pc_o == DBG_ROM_PC);

  // R5
  sup_stack_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sepc_o) |-> redirect_o && prv_o == PRV_S && !status_o[ST_SIE]);

  // R7
  mach_stack_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mepc_o) |-> redirect_o && prv_o == PRV_M && !status_o[ST_MIE]);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !trap_valid_i |=> !redirect_o && !dbg_enter_o && $stable(pc_o)
      && $stable(prv_o) && $stable(status_o));

  // R9
  redirect_src_chk: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> $past(trap_valid_i));
endmodule

bind trap_entry_ctl trap_entry_chk #(
  .XLEN       (XLEN),
  .DBG_ROM_PC (DBG_ROM_PC)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .trap_valid_i (trap_valid_i),
  .dbg_active_i (dbg_active_i),
  .redirect_o   (redirect_o),
  .pc_o         (pc_o),
  .prv_o        (prv_o),
  .status_o     (status_o),
  .scause_o     (scause_o),
  .sepc_o       (sepc_o),
  .mcause_o     (mcause_o),
  .mepc_o       (mepc_o),
  .dbg_enter_o  (dbg_enter_o)
);

// File: tb/trap_entry_ctl_tb_top.sv
module trap_entry_ctl_tb_top;
  localparam int XLEN = 32;
  localparam logic [31:0] RST_PC  = 32'h1000;
  localparam logic [31:0] ROM_PC  = 32'h800;
  localparam logic [31:0] DEXC_PC = 32'h808;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trap_valid_i = 1'b0;
  logic [31:0] trap_cause_i = '0, trap_epc_i = '0, trap_tval_i = '0;
  logic [1:0]  cur_prv_i = 2'd3;
  logic [6:0]  status_i = '0;
  logic [31:0] exc_deleg_i = '0, int_deleg_i = '0, stvec_i = '0, mtvec_i = '0;
  logic dbg_active_i = 1'b0, ebk_m_i = 1'b0, ebk_s_i = 1'b0, ebk_u_i = 1'b0;

  logic        redirect_o, dbg_enter_o;
  logic [31:0] pc_o, scause_o, sepc_o, stval_o, mcause_o, mepc_o, mtval_o, dpc_o;
  logic [1:0]  prv_o, dprv_o;
  logic [6:0]  status_o;

  trap_entry_ctl #(.XLEN(XLEN), .RST_PC(RST_PC), .DBG_ROM_PC(ROM_PC), .DBG_EXC_PC(DEXC_PC)) dut_i (
    .clk(clk), .rst(rst), .trap_valid_i(trap_valid_i), .trap_cause_i(trap_cause_i),
    .trap_epc_i(trap_epc_i), .trap_tval_i(trap_tval_i), .cur_prv_i(cur_prv_i),
    .status_i(status_i), .exc_deleg_i(exc_deleg_i), .int_deleg_i(int_deleg_i),
    .stvec_i(stvec_i), .mtvec_i(mtvec_i), .dbg_active_i(dbg_active_i),
    .ebk_m_i(ebk_m_i), .ebk_s_i(ebk_s_i), .ebk_u_i(ebk_u_i),
    .redirect_o(redirect_o), .pc_o(pc_o), .prv_o(prv_o), .status_o(status_o),
    .scause_o(scause_o), .sepc_o(sepc_o), .stval_o(stval_o), .mcause_o(mcause_o),
    .mepc_o(mepc_o), .mtval_o(mtval_o), .dbg_enter_o(dbg_enter_o), .dpc_o(dpc_o),
    .dprv_o(dprv_o)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // expected model state
  logic [31:0] e_pc, e_sc, e_se, e_sv, e_mc, e_me, e_mv, e_dpc;
  logic [1:0]  e_prv, e_dprv;
  logic [6:0]  e_st;
  logic        e_red, e_den;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "redirect", 32'(redirect_o), 32'(e_red));
    chk(tag, "dbg_enter", 32'(dbg_enter_o), 32'(e_den));
    chk(tag, "pc", pc_o, e_pc);
    chk(tag, "prv", 32'(prv_o), 32'(e_prv));
    chk(tag, "status", 32'(status_o), 32'(e_st));
    chk(tag, "scause", scause_o, e_sc);
    chk(tag, "sepc", sepc_o, e_se);
    chk(tag, "stval", stval_o, e_sv);
    chk(tag, "mcause", mcause_o, e_mc);
    chk(tag, "mepc", mepc_o, e_me);
    chk(tag, "mtval", mtval_o, e_mv);
    chk(tag, "dpc", dpc_o, e_dpc);
    chk(tag, "dprv", 32'(dprv_o), 32'(e_dprv));
  endtask

  // drive one trap at a negedge, predict, check at the following negedge
  task automatic trap(input logic [1:0] prv, input logic [31:0] cause, input logic dbg,
                      input logic [2:0] ebk, input string force_tag);
    logic irq, bk, en, sup;
    logic [30:0] idx;
    logic [31:0] msk;
    string tag;
    trap_cause_i = cause;
    cur_prv_i    = prv;
    dbg_active_i = dbg;
    {ebk_m_i, ebk_s_i, ebk_u_i} = ebk;
    trap_epc_i   = $urandom;
    trap_tval_i  = $urandom;
    status_i     = 7'($urandom);
    trap_valid_i = 1'b1;
    irq = cause[31];
    idx = cause[30:0];
    bk  = !irq && idx == 31'd3;
    en  = (prv == 2'd3) ? ebk[2] : (prv == 2'd1) ? ebk[1] : (prv == 2'd0) ? ebk[0] : 1'b0;
    msk = irq ? int_deleg_i : exc_deleg_i;
    sup = (prv <= 2'd1) && (idx < 31'd32) && msk[idx[4:0]];
    e_red = 1'b1;
    e_den = 1'b0;
    if (dbg) begin
      tag  = "R2";
      e_pc = bk ? ROM_PC : DEXC_PC;
    end else if (bk && en) begin
      tag   = "R3";
      e_den = 1'b1;
      e_pc  = ROM_PC;
      e_dpc = trap_epc_i;
      e_dprv = prv;
      e_prv = 2'd3;
    end else if (sup) begin
      tag  = "R5";
      e_pc = stvec_i;
      e_sc = cause; e_se = trap_epc_i; e_sv = trap_tval_i;
      e_st = status_i;
      e_st[2] = status_i[0];
      e_st[4] = prv[0];
      e_st[0] = 1'b0;
      e_prv = 2'd1;
    end else begin
      tag  = "R7";
      e_pc = {mtvec_i[31:1], 1'b0} + ((mtvec_i[0] && irq) ? (32'(idx) * 32'd4) : 32'd0);
      e_mc = cause; e_me = trap_epc_i; e_mv = trap_tval_i;
      e_st = status_i;
      e_st[3] = status_i[1];
      e_st[6:5] = prv;
      e_st[1] = 1'b0;
      e_prv = 2'd3;
    end
    if (force_tag != "") tag = force_tag;
    @(negedge clk);
    trap_valid_i = 1'b0;
    check_all(tag);
    if (!dbg && !(bk && en))
      chk("R4", "target privilege", 32'(prv_o), sup ? 32'd1 : 32'd3);
    if (!dbg && !(bk && en) && !sup)
      chk("R6", "machine pc", pc_o, e_pc);
    chk("R9", "redirect strobe", 32'(redirect_o), 32'd1);
  endtask

  task automatic idle(input string tag);
    trap_cause_i = $urandom; trap_epc_i = $urandom; cur_prv_i = 2'($urandom);
    status_i = 7'($urandom); dbg_active_i = 1'($urandom);
    trap_valid_i = 1'b0;
    e_red = 1'b0;
    e_den = 1'b0;
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1357));
    e_pc = RST_PC; e_prv = 2'd3; e_st = '0; e_red = 1'b0; e_den = 1'b0;
    e_sc = '0; e_se = '0; e_sv = '0; e_mc = '0; e_me = '0; e_mv = '0; e_dpc = '0; e_dprv = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_all("R1");
    @(negedge clk);

    stvec_i = 32'h0000_4000;
    mtvec_i = 32'h0000_2001;
    exc_deleg_i = 32'h0000_0108;
    int_deleg_i = 32'h0000_0222;

    // R2: in debug mode
    trap(2'd1, 32'd3, 1'b1, 3'b000, "R2");
    trap(2'd0, 32'h8000_0005, 1'b1, 3'b111, "R2");
    // R3: ebreak to debug in each mode
    trap(2'd3, 32'd3, 1'b0, 3'b100, "R3");
    trap(2'd1, 32'd3, 1'b0, 3'b010, "R3");
    trap(2'd0, 32'd3, 1'b0, 3'b001, "R3");
    // R10: enable set for another mode only
    trap(2'd0, 32'd3, 1'b0, 3'b110, "R10");
    trap(2'd3, 32'd3, 1'b0, 3'b011, "R10");
    // R4: delegated exception from U, interrupt from S, same from M not delegated
    trap(2'd0, 32'd8, 1'b0, 3'b000, "R4");
    trap(2'd1, 32'h8000_0009, 1'b0, 3'b000, "R4");
    trap(2'd3, 32'd8, 1'b0, 3'b000, "R4");
    // R6: vectored interrupt and exception under vectored mtvec
    trap(2'd3, 32'h8000_0007, 1'b0, 3'b000, "R6");
    trap(2'd3, 32'd2, 1'b0, 3'b000, "R6");
    // R4: index beyond width never delegates
    exc_deleg_i = '1;
    trap(2'd0, 32'd40, 1'b0, 3'b000, "R4");
    exc_deleg_i = 32'h0000_0108;
    // R8: idle cycles hold
    repeat (4) idle("R8");

    for (int i = 0; i < 600; i++) begin
      logic [31:0] c;
      logic [1:0]  p;
      if ($urandom % 4 == 0) begin
        idle("R8");
      end else begin
        c = ($urandom % 8 == 0) ? 32'(32 + $urandom % 20) : 32'($urandom % 16);
        c[31] = 1'($urandom);
        p = 2'($urandom);
        if (i % 50 == 0) begin
          exc_deleg_i = $urandom; int_deleg_i = $urandom;
          stvec_i = $urandom & 32'hFFFF_FFFC; mtvec_i = $urandom;
        end
        trap(p, c, ($urandom % 10 == 0), 3'($urandom), "");
      end
    end
    finish_run();
  end
endmodule